// File: doc/BRIEF.md
# Mini UART Register Interface

This block is the software-facing side of a reduced auxiliary UART. A host reaches it over a 32-bit register bus. Each access is one word within a 256-byte window. Received bytes come in on a valid/ready byte stream and are held in a small circular receive queue. The host drains that queue through the data register. A write to the data register sends its low byte out at once as a one-cycle strobe.

The transmit side is modelled as always idle and empty. As a result, the transmit interrupt is raised whenever it is enabled. Several status words combine fixed "idle" bits with the live receive state. One of them carries the queue fill level in its upper half. Registers for baud rate, framing, line and modem control, the scratch location and the unused companion functions are decoded but hold nothing. They read as zero and drop writes.

The queue depth is a parameter (default 8). A single level-sensitive interrupt line reports pending receive data or an enabled transmit interrupt.

Top module: `mu_regif`

## Requirements
- R1: After a synchronous active-high reset, the queue is empty, both interrupt enables are clear, `irq` and `tx_valid` are low, and `rx_ready` is high.
- R2: The word at 0x04 reads 1 and the word at 0x60 reads 3. The words at 0x4C, 0x50, 0x58, 0x5C and 0x68, any unlisted offset, and any access whose address bits 1:0 are not zero read 0 and have no effect when written.
- R3: A byte is accepted when `rx_valid` and `rx_ready` are both high, and `rx_ready` is high exactly while the fill level is below the depth. The byte is stored at (head + fill) modulo depth. Bytes offered while the queue is full are dropped. Bytes come back in arrival order across the wrap point.
- R4: Reading the data word (0x40) returns the head byte in bits 7:0. If the queue holds data, the read also advances the head (wrapping at the depth) and lowers the fill level by one. If the queue is empty, the read returns whatever the head slot last held and changes nothing.
- R5: Writing the data word causes `tx_valid` to be high for exactly the following cycle, with `tx_data` equal to bits 7:0 of the write data. Back-to-back writes give back-to-back strobes. No other access strobes.
- R6: A write to the enable word (0x44) keeps only bit 0 (receive) and bit 1 (transmit). Reading it returns 0xC0 OR the two stored bits.
- R7: `irq` is high when the receive enable is set and the queue is not empty, or whenever the transmit enable is set. The word at 0x00 reads `irq` in bit 0.
- R8: The identification word (0x48) reads 0xC0, plus 0x04 if the queue holds data or 0x02 if it is empty, plus 0x01 when `irq` is low.
- R9: Writing the identification word with bit 1 set empties the queue in one cycle and leaves the head position where it was. A byte offered in the same cycle is dropped. A write to this word with bit 1 clear has no effect.
- R10: The line status word (0x54) reads 0x60, with bit 0 set while the queue holds data.
- R11: The extended status word (0x64) reads 0x30E, with bit 0 set while the queue holds data and the fill level placed from bit 16 upward.
- R12: A data read of a non-empty queue in the same cycle as an accepted byte performs both operations, so the fill level is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 8 | Byte address inside the register window |
| bus_rd | input | 1 | Read strobe for one cycle |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_rd` |
| rx_data | input | 8 | Incoming byte |
| rx_valid | input | 1 | Incoming byte present |
| rx_ready | output | 1 | Queue can take a byte this cycle |
| tx_data | output | 8 | Outgoing byte |
| tx_valid | output | 1 | One-cycle strobe for `tx_data` |
| irq | output | 1 | Level interrupt |

## Verification
The hardest situation to reach from the ports is the stale empty read. It is only meaningful after the head slot has been filled, drained or flushed. The stimulus therefore fills the queue to full starting at a non-zero head, so that it wraps, and drains it. Only then does it read once more, expecting the byte that started that pass. A second stale read follows a flush that leaves unread data behind the head, which shows that the head did not move. Cycles that both push and pop, and a flush that coincides with an incoming byte, are built by driving the bus and the byte stream in the same cycle.

// File: rtl/mu_pkg.sv
package mu_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int BYTE_W = 8;
    localparam int WORD_W = ADDR_W - 2;

    // word indices (byte offset / 4)
    localparam logic [WORD_W-1:0] WA_IRQ  = 6'h00;
    localparam logic [WORD_W-1:0] WA_EN   = 6'h01;
    localparam logic [WORD_W-1:0] WA_DATA = 6'h10;
    localparam logic [WORD_W-1:0] WA_IEN  = 6'h11;
    localparam logic [WORD_W-1:0] WA_IID  = 6'h12;
    localparam logic [WORD_W-1:0] WA_LINE = 6'h15;
    localparam logic [WORD_W-1:0] WA_CTL  = 6'h18;
    localparam logic [WORD_W-1:0] WA_XST  = 6'h19;

    localparam logic [DATA_W-1:0] EN_FIXED   = 32'h0000_0001;
    localparam logic [DATA_W-1:0] CTL_FIXED  = 32'h0000_0003;
    localparam logic [DATA_W-1:0] FIFO_BITS  = 32'h0000_00C0;
    localparam logic [DATA_W-1:0] LINE_IDLE  = 32'h0000_0060;
    localparam logic [DATA_W-1:0] XST_IDLE   = 32'h0000_030E;
    localparam int                LEVEL_LSB  = 16;

    typedef struct packed {
        logic pop;
        logic flush;
        logic ien_we;
        logic tx_we;
    } bus_cmd_t;

endpackage

// File: rtl/mu_rx_fifo.sv
module mu_rx_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_valid,
    input  logic [W-1:0]  push_data,
    output logic          push_ready,
    input  logic          pop,
    input  logic          flush,
    output logic [W-1:0]  head_data,
    output logic [CW-1:0] fill
);

    localparam logic [CW:0]   DEPTH_X  = (CW+1)'(DEPTH);
    localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);

    typedef struct packed {
        logic [PW-1:0] head;
        logic [CW-1:0] count;
    } fifo_st_t;

    fifo_st_t      st_d, st_q;
    logic [W-1:0]  mem [DEPTH];
    logic          do_push, do_pop;
    logic [CW:0]   slot_sum;
    logic [PW-1:0] wr_idx;

    always_comb begin
        push_ready = (st_q.count < CW'(DEPTH));
        do_push    = push_valid && push_ready && !flush;
        do_pop     = pop && (st_q.count != '0) && !flush;

        slot_sum = (CW+1)'(st_q.head) + (CW+1)'(st_q.count);
        if (slot_sum >= DEPTH_X) begin
            wr_idx = PW'(slot_sum - DEPTH_X);
        end else begin
            wr_idx = PW'(slot_sum);
        end

        st_d = st_q;
        if (flush) begin
            st_d.count = '0;
        end else begin
            if (do_pop) begin
                st_d.head = (st_q.head == LAST_PTR) ? '0 : st_q.head + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   st_d.count = st_q.count + 1'b1;
                2'b01:   st_d.count = st_q.count - 1'b1;
                default: st_d.count = st_q.count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_idx] <= push_data;
        end
    end

    assign head_data = mem[st_q.head];
    assign fill      = st_q.count;

endmodule

// File: rtl/mu_irq_ctrl.sv
module mu_irq_ctrl (
    input  logic       clk,
    input  logic       rst,
    input  logic       ien_we,
    input  logic [1:0] ien_wdata,
    input  logic       rx_nonempty,
    output logic [1:0] ien,
    output logic       irq
);

    typedef struct packed {
        logic [1:0] en;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ien_we) begin
            st_d.en = ien_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // bit 0: receive data pending, bit 1: transmitter always empty
    assign ien = st_q.en;
    assign irq = (st_q.en[0] && rx_nonempty) || st_q.en[1];

endmodule

// File: rtl/mu_tx_strobe.sv
module mu_tx_strobe #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] wbyte,
    output logic         tx_valid,
    output logic [W-1:0] tx_data
);

    typedef struct packed {
        logic         valid;
        logic [W-1:0] data;
    } tx_st_t;

    tx_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = we;
        if (we) begin
            st_d.data = wbyte;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_valid = st_q.valid;
    assign tx_data  = st_q.data;

endmodule

// File: rtl/mu_reg_decode.sv
module mu_reg_decode
    import mu_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic [1:0]        wctl,
    input  logic              irq,
    input  logic [1:0]        ien,
    input  logic [CW-1:0]     fill,
    input  logic [BYTE_W-1:0] head,
    output logic [DATA_W-1:0] rdata,
    output bus_cmd_t          cmd
);

    logic              aligned;
    logic [WORD_W-1:0] word;
    logic              nonempty;
    logic [DATA_W-1:0] level_word;

    always_comb begin
        aligned    = (addr[1:0] == 2'b00);
        word       = addr[ADDR_W-1:2];
        nonempty   = (fill != '0);
        level_word = DATA_W'(fill) << LEVEL_LSB;

        rdata = '0;
        if (aligned) begin
            case (word)
                WA_IRQ:  rdata = DATA_W'(irq);
                WA_EN:   rdata = EN_FIXED;
                WA_DATA: rdata = DATA_W'(head);
                WA_IEN:  rdata = FIFO_BITS | DATA_W'(ien);
                WA_IID:  rdata = FIFO_BITS
                               | (nonempty ? 32'h4 : 32'h2)
                               | (irq ? 32'h0 : 32'h1);
                WA_LINE: rdata = LINE_IDLE | DATA_W'(nonempty);
                WA_CTL:  rdata = CTL_FIXED;
                WA_XST:  rdata = XST_IDLE | DATA_W'(nonempty) | level_word;
                default: rdata = '0;
            endcase
        end

        cmd.pop    = rd && aligned && (word == WA_DATA);
        cmd.tx_we  = wr && aligned && (word == WA_DATA);
        cmd.ien_we = wr && aligned && (word == WA_IEN);
        cmd.flush  = wr && aligned && (word == WA_IID) && wctl[1];
    end

endmodule

// File: rtl/mu_regif.sv
module mu_regif
    import mu_pkg::*;
#(
    parameter int RX_DEPTH = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_rd,
    input  logic                  bus_wr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic [BYTE_W-1:0]     rx_data,
    input  logic                  rx_valid,
    output logic                  rx_ready,
    output logic [BYTE_W-1:0]     tx_data,
    output logic                  tx_valid,
    output logic                  irq
);

    localparam int CW = $clog2(RX_DEPTH + 1);

    bus_cmd_t          cmd;
    logic [CW-1:0]     fill_cnt;
    logic [BYTE_W-1:0] head_byte;
    logic [1:0]        ien_bits;
    logic              unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:BYTE_W];

    mu_reg_decode #(.CW(CW)) u_dec (
        .addr  (bus_addr),
        .rd    (bus_rd),
        .wr    (bus_wr),
        .wctl  (bus_wdata[1:0]),
        .irq   (irq),
        .ien   (ien_bits),
        .fill  (fill_cnt),
        .head  (head_byte),
        .rdata (bus_rdata),
        .cmd   (cmd)
    );

    mu_rx_fifo #(.DEPTH(RX_DEPTH), .W(BYTE_W)) u_fifo (
        .clk        (clk),
        .rst        (rst),
        .push_valid (rx_valid),
        .push_data  (rx_data),
        .push_ready (rx_ready),
        .pop        (cmd.pop),
        .flush      (cmd.flush),
        .head_data  (head_byte),
        .fill       (fill_cnt)
    );

    mu_irq_ctrl u_irq (
        .clk         (clk),
        .rst         (rst),
        .ien_we      (cmd.ien_we),
        .ien_wdata   (bus_wdata[1:0]),
        .rx_nonempty (fill_cnt != '0),
        .ien         (ien_bits),
        .irq         (irq)
    );

    mu_tx_strobe #(.W(BYTE_W)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .we       (cmd.tx_we),
        .wbyte    (bus_wdata[BYTE_W-1:0]),
        .tx_valid (tx_valid),
        .tx_data  (tx_data)
    );

endmodule

// File: rtl/mu_regif_chk.sv
module mu_regif_chk
    import mu_pkg::*;
#(
    parameter int RX_DEPTH = 8,
    parameter int CW       = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic [BYTE_W-1:0] tx_data,
    input logic              tx_valid,
    input logic              irq,
    input logic [CW-1:0]     fill
);

    logic wr_data, rd_data, wr_ien, wr_iid;
    assign wr_data = bus_wr && (bus_addr == {WA_DATA, 2'b00});
    assign rd_data = bus_rd && (bus_addr == {WA_DATA, 2'b00});
    assign wr_ien  = bus_wr && (bus_addr == {WA_IEN, 2'b00});
    assign wr_iid  = bus_wr && (bus_addr == {WA_IID, 2'b00});

    assert_tx_strobe_R5: assert property (@(posedge clk) disable iff (rst)
        wr_data |=> (tx_valid && tx_data == $past(bus_wdata[BYTE_W-1:0])));

    assert_tx_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        !wr_data |=> !tx_valid);

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        fill <= CW'(RX_DEPTH));

    assert_full_holds_R3: assert property (@(posedge clk) disable iff (rst)
        (!rx_ready && !bus_rd && !bus_wr) |=> $stable(fill));

    assert_empty_read_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_data && !bus_wr && fill == '0 && !rx_valid) |=> fill == '0);

    assert_tx_irq_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_ien && bus_wdata[1]) |=> irq);

    assert_flush_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_iid && bus_wdata[1]) |=> fill == '0);

    assert_push_pop_R12: assert property (@(posedge clk) disable iff (rst)
        (rd_data && !bus_wr && fill != '0 && rx_ready && rx_valid) |=> $stable(fill));

endmodule

bind mu_regif mu_regif_chk #(.RX_DEPTH(RX_DEPTH), .CW(CW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .rx_valid  (rx_valid),
    .rx_ready  (rx_ready),
    .tx_data   (tx_data),
    .tx_valid  (tx_valid),
    .irq       (irq),
    .fill      (fill_cnt)
);

// File: tb/mu_regif_test.sv
`timescale 1ns/1ps
module mu_regif_test;

    localparam logic [7:0] A_IRQ  = 8'h00;
    localparam logic [7:0] A_EN   = 8'h04;
    localparam logic [7:0] A_DATA = 8'h40;
    localparam logic [7:0] A_IEN  = 8'h44;
    localparam logic [7:0] A_IID  = 8'h48;
    localparam logic [7:0] A_LINE = 8'h54;
    localparam logic [7:0] A_CTL  = 8'h60;
    localparam logic [7:0] A_XST  = 8'h64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  rx_data = '0;
    logic        rx_valid = 1'b0;
    logic        rx_ready;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [31:0] rd_q[$];
    string       rd_tag[$];
    logic [7:0]  tx_q[$];
    string       tx_tag[$];

    always #2 clk = ~clk;

    mu_regif uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .tx_data(tx_data), .tx_valid(tx_valid), .irq(irq)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // monitor: compares read data and transmit strobes against the scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (bus_rd) begin
                if (rd_q.size() == 0) begin
                    chk(bus_rdata, 32'hDEAD_BEEF, "unexpected read");
                end else begin
                    chk(bus_rdata, rd_q.pop_front(), rd_tag.pop_front());
                end
            end
            if (tx_valid) begin
                if (tx_q.size() == 0) begin
                    chk({24'h0, tx_data}, 32'hFFFF_FFFF, "R5 unexpected tx strobe");
                end else begin
                    chk({24'h0, tx_data}, {24'h0, tx_q.pop_front()}, tx_tag.pop_front());
                end
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        rd_q.push_back(e); rd_tag.push_back(tag);
        bus_addr = a; bus_rd = 1'b1;
        step();
        bus_rd = 1'b0;
    endtask

    task automatic txw(input logic [31:0] d);
        tx_q.push_back(d[7:0]); tx_tag.push_back("R5 tx byte");
        wr(A_DATA, d);
    endtask

    task automatic rxb(input logic [7:0] b);
        rx_data = b; rx_valid = 1'b1;
        step();
        rx_valid = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        chk(0, 1, "watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        chk(irq, 0, "R1 irq");
        chk(rx_ready, 1, "R1 rx_ready");
        chk(tx_valid, 0, "R1 tx_valid");
        rd(A_IEN, 32'hC0, "R1 R6 enable word");
        rd(A_XST, 32'h30E, "R1 R11 extended status");
        rd(A_LINE, 32'h60, "R10 line status empty");
        rd(A_IID, 32'hC3, "R8 ident idle");
        rd(A_IRQ, 32'h0, "R7 irq word low");

        // R2 fixed and dead words
        rd(A_EN, 32'h1, "R2 enables word");
        rd(A_CTL, 32'h3, "R2 control word");
        wr(8'h4C, 32'hFF); wr(8'h5C, 32'hAB); wr(8'h68, 32'hFFFF);
        wr(8'hC0, 32'h3); wr(8'h45, 32'h3); wr(8'h41, 32'h55);
        rd(8'h4C, 32'h0, "R2 dead 4C");
        rd(8'h50, 32'h0, "R2 dead 50");
        rd(8'h58, 32'h0, "R2 dead 58");
        rd(8'h5C, 32'h0, "R2 dead 5C");
        rd(8'h68, 32'h0, "R2 dead 68");
        rd(8'hC0, 32'h0, "R2 unmapped C0");
        rd(8'hFC, 32'h0, "R2 unmapped FC");
        rd(8'h46, 32'h0, "R2 misaligned read");
        rd(A_IEN, 32'hC0, "R2 misaligned write ignored");
        chk(irq, 0, "R2 irq untouched");

        // R5 transmit strobes
        txw(32'h0000_01A5);
        txw(32'h11);
        txw(32'h22);
        repeat (2) step();

        // R3 R4 R7 R8 R10 R11 receive path
        rxb(8'h10); rxb(8'h20); rxb(8'h30);
        rd(A_XST, 32'h0003_030F, "R11 level 3");
        rd(A_LINE, 32'h61, "R10 data present");
        rd(A_IID, 32'hC5, "R8 data, no irq");
        rd(A_IRQ, 32'h0, "R7 rx disabled");
        wr(A_IEN, 32'h1);
        chk(irq, 1, "R7 rx irq");
        rd(A_IEN, 32'hC1, "R6 rx enable");
        rd(A_IID, 32'hC4, "R8 data pending");
        rd(A_IRQ, 32'h1, "R7 irq word high");
        rd(A_DATA, 32'h10, "R4 pop 1");
        rd(A_DATA, 32'h20, "R4 pop 2");
        rd(A_DATA, 32'h30, "R4 pop 3");
        chk(irq, 0, "R7 empty drops irq");
        rd(A_IID, 32'hC3, "R8 empty again");

        // R3 fill to full across the wrap point
        for (int i = 0; i < 8; i++) rxb(8'(8'h40 + i));
        chk(rx_ready, 0, "R3 full not ready");
        chk(irq, 1, "R7 irq full");
        rd(A_XST, 32'h0008_030F, "R11 level 8");
        rxb(8'h99);
        rd(A_XST, 32'h0008_030F, "R3 full drop");
        for (int i = 0; i < 8; i++) rd(A_DATA, 32'(8'h40 + i), "R3 order across wrap");
        rd(A_XST, 32'h30E, "R4 drained");
        rd(A_DATA, 32'h40, "R4 stale empty read");
        rd(A_XST, 32'h30E, "R4 empty read no change");
        chk(rx_ready, 1, "R3 ready again");

        // R6 R7 R8 transmit interrupt
        wr(A_IEN, 32'h2);
        chk(irq, 1, "R7 tx irq while empty");
        rd(A_IID, 32'hC2, "R8 pending, empty");
        rd(A_IRQ, 32'h1, "R7 irq word tx");
        wr(A_IEN, 32'hFF);
        rd(A_IEN, 32'hC3, "R6 only two bits kept");

        // R9 flush
        wr(A_IEN, 32'h0);
        chk(irq, 0, "R7 all disabled");
        rxb(8'h61); rxb(8'h62); rxb(8'h63);
        rd(A_DATA, 32'h61, "R4 pop before flush");
        wr(A_IID, 32'h4);
        rd(A_XST, 32'h0002_030F, "R9 bit1 clear no flush");
        wr(A_IID, 32'h2);
        rd(A_XST, 32'h30E, "R9 flushed");
        rd(A_LINE, 32'h60, "R9 R10 empty after flush");
        rd(A_DATA, 32'h62, "R9 head kept");
        rxb(8'h70);
        rx_data = 8'h72; rx_valid = 1'b1;
        wr(A_IID, 32'h6);
        rx_valid = 1'b0;
        rd(A_XST, 32'h30E, "R9 flush drops same-cycle byte");
        rxb(8'h74);
        rd(A_DATA, 32'h74, "R9 refill after flush");

        // R12 simultaneous push and pop
        rxb(8'h81);
        rx_data = 8'h82; rx_valid = 1'b1;
        rd(A_DATA, 32'h81, "R12 pop during push");
        rx_valid = 1'b0;
        rd(A_XST, 32'h0001_030F, "R12 level unchanged");
        rd(A_DATA, 32'h82, "R12 pushed byte");
        rd(A_XST, 32'h30E, "R12 empty");

        repeat (3) step();
        chk(rd_q.size(), 0, "scoreboard reads drained");
        chk(tx_q.size(), 0, "R5 scoreboard tx drained");
        finish_run();
    end

endmodule